// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns host-written words into an asynchronous serial bitstream. It has two storage stages: a holding buffer that takes the host's write, and an output shifter that drives the line. The host composes each word itself. The data bits sit in the low end, followed at once by one or two stop bits set to 1, and everything above them is 0. The block adds a low start bit, sends the word least significant bit first, and ends the frame once only zeros remain. Word length and stop-bit count therefore come from the written value alone. No mode input affects transmission.

Each bit lasts `rate + 1` clock cycles. The host sees two status outputs. The first says the buffer has been emptied. The second says the line finished a frame with nothing left to send. The first of these also drives an interrupt request, and a single acknowledge strobe clears both. A break input holds the line low and freezes the transmitter where it stands. Releasing break lets the frame continue from that point.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset the line output is high, `buf_empty` is 1, `shift_empty` is 1 and `irq` is 1.
- R2: Every transmitted bit, start bit included, holds the line for exactly `rate + 1` clock cycles.
- R3: A frame is a 0 start bit, then the written word from bit 0 upward, up to and including its highest 1 bit. After that the line is high when nothing is pending. A word of 8 data bits with 1 stop bit (bit 8 set) takes 10 bit times, 2 stop bits (bits 8 and 9 set) take 11, and 9 data bits with a stop bit at bit 9 take 11.
- R4: A word written while the line is idle moves into the shifter on the next clock edge after the write is captured, and the start bit begins on that edge.
- R5: `buf_empty` sets on the edge where a buffered word moves into the shifter, and stays set until `empty_ack` is pulsed. `irq` equals `buf_empty`.
- R6: `shift_empty` sets when a frame ends and no word is waiting. It is cleared only by `empty_ack`; loading a new word into the shifter does not clear it.
- R7: While `brk` is 1 the line output is 0 and the bit timer, shifter and buffer transfer are frozen. After `brk` falls, the interrupted bit resumes with its remaining time.
- R8: A word waiting in the buffer is loaded on the bit boundary that ends the previous frame's last stop bit, with no idle time between the frames.
- R9: A write while the buffer still holds an unsent word replaces that word, and only the newest word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe for the holding buffer |
| wr_word | input | 16 | Word to send: data, then stop bits, then zeros |
| rate | input | 15 | Bit period minus one, in clock cycles |
| brk | input | 1 | Break: force the line low and freeze transmission |
| empty_ack | input | 1 | Acknowledge strobe clearing both empty flags |
| txd | output | 1 | Serial line output, idle high |
| buf_empty | output | 1 | Holding buffer has handed its word to the shifter |
| shift_empty | output | 1 | Frame finished with no word pending |
| irq | output | 1 | Interrupt request, mirrors buf_empty |

## Verification
The frame table mixes word shapes so that each one exposes a different fault. It has 8 data bits with one or two stop bits, 9 data bits, an all-zero data byte, and alternating patterns. Together these show whether the frame length really follows the highest set bit, and whether bit order and the end-of-frame test are right. The table also uses bit periods from 1 to 6 cycles, which catches off-by-one errors in the period counter. Directed runs cover three more cases. A back-to-back pair checks that the second frame starts on the final stop-bit boundary. A double write while busy checks that the later word replaces the earlier one. A break pulse in the middle of a bit checks that the line drops and the bit's remaining time is kept.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;

    localparam int DEF_WORD_W = 16;
    localparam int DEF_RATE_W = 15;

    typedef enum logic [1:0] {
        LINE_IDLE  = 2'd0,
        LINE_SHIFT = 2'd1,
        LINE_BREAK = 2'd2
    } line_sel_e;

    typedef struct packed {
        logic buf_empty;
        logic shift_empty;
    } tx_flags_t;

    function automatic logic line_level(input line_sel_e sel, input logic shift_bit);
        case (sel)
            LINE_SHIFT: return shift_bit;
            LINE_BREAK: return 1'b0;
            default:    return 1'b1;
        endcase
    endfunction

    function automatic line_sel_e pick_line(input logic brk, input logic busy);
        if (brk)       return LINE_BREAK;
        else if (busy) return LINE_SHIFT;
        else           return LINE_IDLE;
    endfunction

endpackage

// File: rtl/uart_dbuf_timer.sv
module uart_dbuf_timer #(
    parameter int RATE_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= rate);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q >= rate) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/uart_dbuf_hold.sv
module uart_dbuf_hold #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            word <= '0;
        end else if (wr_en) begin
            full <= 1'b1;
            word <= wr_word;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_dbuf_shifter.sv
module uart_dbuf_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              tick,
    output logic              busy,
    output logic              bit_out,
    output logic              frame_end,
    output logic [WORD_W:0]   frame
);
    localparam int FR_W = WORD_W + 1;

    logic [FR_W-1:0] next_fr;

    assign next_fr   = frame >> 1;
    assign frame_end = tick && busy && (next_fr == '0);
    assign bit_out   = frame[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            frame <= '0;
        end else if (load) begin
            busy  <= 1'b1;
            frame <= {load_word, 1'b0};
        end else if (tick && busy) begin
            if (next_fr == '0) begin
                busy  <= 1'b0;
                frame <= '0;
            end else begin
                frame <= next_fr;
            end
        end
    end
endmodule

// File: rtl/uart_dbuf_flags.sv
module uart_dbuf_flags
    import uart_dbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      frame_idle,
    input  logic      ack,
    output tx_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '{buf_empty: 1'b1, shift_empty: 1'b1};
        end else begin
            if (load)     flags.buf_empty <= 1'b1;
            else if (ack) flags.buf_empty <= 1'b0;
            if (frame_idle) flags.shift_empty <= 1'b1;
            else if (ack)   flags.shift_empty <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
    import uart_dbuf_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int RATE_W = DEF_RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [RATE_W-1:0] rate,
    input  logic              brk,
    input  logic              empty_ack,
    output logic              txd,
    output logic              buf_empty,
    output logic              shift_empty,
    output logic              irq
);
    logic              hold_full;
    logic [WORD_W-1:0] hold_word;
    logic              busy_s;
    logic              bit_s;
    logic              frame_end_s;
    logic              tick_s;
    logic              load_s;
    logic              frame_idle_s;
    logic [WORD_W:0]   frame_q;
    tx_flags_t         flags_q;

    // A pending word moves in when the line is free or the last stop bit ends.
    assign load_s       = !brk && hold_full && (!busy_s || frame_end_s);
    assign frame_idle_s = frame_end_s && !load_s;

    uart_dbuf_timer #(.RATE_W(RATE_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (load_s),
        .run     (busy_s && !brk),
        .rate    (rate),
        .tick    (tick_s)
    );

    uart_dbuf_hold #(.WORD_W(WORD_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .take    (load_s),
        .full    (hold_full),
        .word    (hold_word)
    );

    uart_dbuf_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load_s),
        .load_word (hold_word),
        .tick      (tick_s),
        .busy      (busy_s),
        .bit_out   (bit_s),
        .frame_end (frame_end_s),
        .frame     (frame_q)
    );

    uart_dbuf_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .load       (load_s),
        .frame_idle (frame_idle_s),
        .ack        (empty_ack),
        .flags      (flags_q)
    );

    assign txd         = line_level(pick_line(brk, busy_s), bit_s);
    assign buf_empty   = flags_q.buf_empty;
    assign shift_empty = flags_q.shift_empty;
    assign irq         = flags_q.buf_empty;
endmodule

// File: rtl/uart_dbuf_tx_chk.sv
module uart_dbuf_tx_chk #(
    parameter int WORD_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            brk,
    input logic            empty_ack,
    input logic            txd,
    input logic            buf_empty,
    input logic            shift_empty,
    input logic            load_s,
    input logic            frame_idle_s,
    input logic [WORD_W:0] frame_q
);
    AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
        brk |-> !txd);                                            // R7
    AST_BREAK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        brk |=> $stable(frame_q));                                // R7
    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        load_s |=> !txd);                                         // R4
    AST_LOAD_SETS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        load_s |=> buf_empty);                                    // R5
    AST_ACK_CLEARS_BUF: assert property (@(posedge clk) disable iff (rst)
        (empty_ack && !load_s) |=> !buf_empty);                   // R5
    AST_ACK_CLEARS_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (empty_ack && !frame_idle_s) |=> !shift_empty);           // R6
endmodule

bind uart_dbuf_tx uart_dbuf_tx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .brk          (brk),
    .empty_ack    (empty_ack),
    .txd          (txd),
    .buf_empty    (buf_empty),
    .shift_empty  (shift_empty),
    .load_s       (load_s),
    .frame_idle_s (frame_idle_s),
    .frame_q      (frame_q)
);

// File: tb/sim_uart_dbuf_tx.sv
`timescale 1ns/1ps
module sim_uart_dbuf_tx;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_word = '0;
    logic [14:0] rate = 15'd3;
    logic        brk = 1'b0;
    logic        empty_ack = 1'b0;
    logic        txd, buf_empty, shift_empty, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_dbuf_tx u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .rate(rate),
        .brk(brk), .empty_ack(empty_ack), .txd(txd), .buf_empty(buf_empty),
        .shift_empty(shift_empty), .irq(irq)
    );

    // {rate, word}: 8+1 stop, 8+2 stop, 9+1 stop, rate 0, zero data, 9-bit alternating
    localparam logic [30:0] VEC [6] = '{
        {15'd3, 16'h01A5},
        {15'd4, 16'h03C3},
        {15'd2, 16'h03FF},
        {15'd0, 16'h0155},
        {15'd5, 16'h0100},
        {15'd1, 16'h02AA}
    };

    function automatic int flen(input logic [15:0] w);
        int r = 1;
        for (int i = 0; i < 16; i++) if (w[i]) r = i + 2;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk); wr_en = 1'b1; wr_word = w;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); empty_ack = 1'b1;
        @(negedge clk); empty_ack = 1'b0;
    endtask

    // Watch the line once per cycle from the first negedge after the load edge.
    task automatic watch(input logic [63:0] fr, input int total, input int per,
                         input int wn1, input logic [15:0] ww1,
                         input int wn2, input logic [15:0] ww2,
                         input int bfrom, input int blen, input string req);
        int p = 0;
        bit bad = 0;
        logic got = 1'b0, want = 1'b0;
        for (int n = 0; n < total * per + blen + 3; n++) begin
            @(negedge clk);
            if (n == wn1) begin wr_en = 1'b1; wr_word = ww1; end
            else if (n == wn2) begin wr_en = 1'b1; wr_word = ww2; end
            else wr_en = 1'b0;
            brk = (n >= bfrom) && (n < bfrom + blen);
            #1;
            if (brk) want = 1'b0;
            else if (p / per < total) want = fr[p / per];
            else want = 1'b1;
            if (!bad && txd !== want) begin bad = 1; got = txd; end
            if (!brk) p++;
        end
        wr_en = 1'b0;
        brk = 1'b0;
        check(!bad, req, int'(got), int'(!got));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(txd === 1'b1 && buf_empty === 1'b1 && shift_empty === 1'b1 && irq === 1'b1,
              "R1 reset state", {txd, buf_empty, shift_empty, irq}, 4'hF);

        // R6: loading into the shifter does not clear shift_empty
        rate = 15'd3;
        send(16'h01A5);
        @(negedge clk);
        check(txd === 1'b0 && shift_empty === 1'b1 && buf_empty === 1'b1,
              "R6 R4 load keeps shift_empty", {txd, shift_empty, buf_empty}, 3'b011);
        repeat (50) @(negedge clk);

        // Table of frames
        for (int i = 0; i < 6; i++) begin
            logic [15:0] w;
            int per;
            w = VEC[i][15:0];
            rate = VEC[i][30:16];
            per = int'(VEC[i][30:16]) + 1;
            ack();
            check(buf_empty === 1'b0 && irq === 1'b0 && shift_empty === 1'b0,
                  "R5 R6 ack clears", {buf_empty, irq, shift_empty}, 0);
            send(w);
            watch(64'(w) << 1, flen(w), per, -1, '0, -1, '0, -100, 0, "R2 R3 R4 frame");
            check(buf_empty === 1'b1 && irq === 1'b1, "R5 set on load", {buf_empty, irq}, 3);
            check(shift_empty === 1'b1, "R6 set at frame end", int'(shift_empty), 1);
        end

        // R8: back-to-back, second frame starts on final stop-bit boundary
        rate = 15'd2;
        ack();
        send(16'h01A5);
        watch((64'(16'h01A5) << 1) | (64'(16'h0155) << (1 + flen(16'h01A5))),
              flen(16'h01A5) + flen(16'h0155), 3, 0, 16'h0155, -1, '0, -100, 0, "R8 back-to-back");
        check(shift_empty === 1'b1, "R8 R6 idle after pair", int'(shift_empty), 1);

        // R9: second write while pending replaces the first
        rate = 15'd1;
        ack();
        send(16'h01FF);
        watch((64'(16'h01FF) << 1) | (64'(16'h013C) << (1 + flen(16'h01FF))),
              flen(16'h01FF) + flen(16'h013C), 2, 0, 16'h01C3, 2, 16'h013C, -100, 0, "R9 replace");

        // R7: break mid-bit holds line low and freezes timing
        rate = 15'd3;
        ack();
        send(16'h01A5);
        watch(64'(16'h01A5) << 1, flen(16'h01A5), 4, -1, '0, -1, '0, 5, 7, "R7 break");
        check(txd === 1'b1, "R7 R3 idle after break frame", int'(txd), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule